// File: doc/BRIEF.md
# Timed-Unlock Configuration Register

This block holds an 8-bit control register whose low four bits form a protected setting, for example the division ratio of a downstream clock divider. The setting cannot be changed by a single stray bus write. Software first writes an unlock pattern, which sets an enable flag in the top bit. It then writes the new setting within a short window. If the second write does not arrive in time, the flag drops by itself and the setting stays as it was.

When an update is accepted, the block presents the new setting and raises a one-cycle load pulse in the same cycle. The downstream logic uses that pulse to take up the value. A strap input chooses one of two reset values for the setting, so that a fast clock source can start divided. The register reads back through a plain combinational read port.

Top module: `unlock_cfg_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the enable flag is 0 and load_o is 0. field_o is 4'b0011 when strap_slow is 1 and 4'b0000 when strap_slow is 0.
- R2: rd_data returns the enable flag in bit 7, zeros in bits 6..4 and field_o in bits 3..0, whatever values were written to bits 6..4.
- R3: When the flag is clear, only a write of exactly 8'h80 sets it, in the cycle after the write. Any other value, including 8'h80 with any of bits 6..0 set, leaves the flag clear.
- R4: After the flag is set, writes sampled on the 1st to 4th clock edges after the unlock write see it set. If no field write is made, the flag is clear from the 4th edge on, so a write on the 5th edge is not accepted.
- R5: Writing 8'h80 again while the flag is set neither restarts the four-cycle window nor clears the flag.
- R6: A write with bit 7 equal to 0, made while the flag is set, loads bits 3..0 into field_o, clears the flag, and raises load_o for exactly one cycle, all in the cycle after the write.
- R7: A write with bit 7 equal to 1 while the flag is set, or any write while the flag is clear, leaves field_o unchanged and produces no load pulse. A write with bit 7 equal to 1 and other bits set also does not clear the flag.
- R8: load_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_slow | input | 1 | Selects the reset value of the setting (1: 4'b0011, 0: 4'b0000); held static |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| field_o | output | 4 | Current protected setting |
| load_o | output | 1 | One-cycle pulse when field_o takes a new value |

## Verification
Two functions can fall on the same clock edge. One is the automatic expiry of the window on the 4th edge. The other is a field write, or a repeated unlock write, sampled on that same edge. The bench provokes both collisions. It sweeps the field write across the 1st to 5th edge after unlocking and places a re-unlock at several points inside the window. On every cycle, a reference model decides whether the write still counted, and the bench compares field_o, load_o and rd_data with that model.

// File: rtl/unlock_cfg_reg.sv
module unlock_cfg_reg #(
  parameter int FIELD_W = 4,
  parameter int WINDOW  = 4,
  parameter logic [FIELD_W-1:0] ALT_RESET = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strap_slow,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic [FIELD_W-1:0] field_o,
  output logic               load_o
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [7:0] UNLOCK = 8'h80;

  logic             en;
  logic [CNT_W-1:0] cnt;

  wire arm_hit   = wr_en && !en && (wr_data == UNLOCK);
  wire field_hit = wr_en && en && !wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (field_hit) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (arm_hit) begin
      en  <= 1'b1;
      cnt <= CNT_W'(WINDOW);
    end else if (en) begin
      if (cnt == CNT_W'(1)) en <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_o <= strap_slow ? ALT_RESET : '0;
      load_o  <= 1'b0;
    end else begin
      load_o <= field_hit;
      if (field_hit) field_o <= wr_data[FIELD_W-1:0];
    end
  end

  assign rd_data = {en, {(7-FIELD_W){1'b0}}, field_o};

  logic [CNT_W:0] en_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_age <= '0;
    else if (!en) en_age <= '0;
    else          en_age <= en_age + 1'b1;
  end

  AST_ARM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(wr_en && wr_data == UNLOCK)) |=> !en); // R3
  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (en_age < (CNT_W+1)'(WINDOW))); // R4
  AST_REARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && wr_data == UNLOCK && cnt != CNT_W'(1)) |=> en); // R5
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && !wr_data[7]) |=> (load_o && !en && field_o == $past(wr_data[FIELD_W-1:0]))); // R6
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && wr_en && !wr_data[7]) |=> ($stable(field_o) && !load_o)); // R7
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R8
endmodule

// File: tb/unlock_cfg_reg_bench.sv
module unlock_cfg_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_slow = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] field_o;
  logic load_o;

  always #5 clk = ~clk;

  unlock_cfg_reg u_unlock_cfg_reg (
    .clk(clk), .rst_n(rst_n), .strap_slow(strap_slow), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .field_o(field_o), .load_o(load_o));

  typedef struct {
    logic [7:0] rd;
    logic [3:0] fld;
    logic       ld;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit m_en;
  int m_cnt;
  logic [3:0] m_field;

  function automatic exp_t mk(string tag, bit ld);
    exp_t e;
    e.rd = {m_en, 3'b000, m_field};
    e.fld = m_field;
    e.ld = ld;
    e.tag = tag;
    return e;
  endfunction

  task automatic check_now(exp_t e);
    compared++;
    if (rd_data !== e.rd || field_o !== e.fld || load_o !== e.ld) begin
      mismatched++;
      $display("FAIL %s: rd=%h fld=%h ld=%b expected rd=%h fld=%h ld=%b",
               e.tag, rd_data, field_o, load_o, e.rd, e.fld, e.ld);
    end
  endtask

  task automatic do_reset(bit strap);
    @(negedge clk);
    strap_slow = strap;
    wr_en = 0;
    rst_n = 0;
    m_en = 0; m_cnt = 0; m_field = strap ? 4'b0011 : 4'b0000;
    #1;
    check_now(mk("R1", 0));
    @(negedge clk);
    rst_n = 1;
    #1;
    check_now(mk("R1", 0));
  endtask

  task automatic step(bit w, logic [7:0] d, string tag);
    bit ld;
    @(negedge clk);
    wr_en = w;
    wr_data = d;
    ld = 0;
    if (w && m_en && !d[7]) begin
      m_field = d[3:0]; m_en = 0; m_cnt = 0; ld = 1;
    end else if (w && !m_en && d == 8'h80) begin
      m_en = 1; m_cnt = 4;
    end else if (m_en) begin
      if (m_cnt == 1) m_en = 0;
      m_cnt--;
    end
    q.push_back(mk(tag, ld));
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) check_now(q.pop_front());
  end

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    // R4: field write placed 1..5 edges after unlock
    for (int d = 1; d <= 5; d++) begin
      step(1, 8'h80, "R3");
      for (int i = 1; i < d; i++) step(0, 8'h00, "R4");
      step(1, 8'h00 | 8'(d + 4), "R4");
      step(0, 8'h00, "R6");
      step(0, 8'h00, "R8");
      repeat (4) step(0, 8'h00, "R4");
    end
    // R5: re-arm inside window at each offset, then write late
    for (int r = 1; r <= 3; r++) begin
      step(1, 8'h80, "R3");
      for (int i = 1; i < r; i++) step(0, 8'h00, "R5");
      step(1, 8'h80, "R5");
      for (int i = r + 1; i < 5; i++) step(0, 8'h00, "R5");
      step(1, 8'h0c, "R5");
      repeat (5) step(0, 8'h00, "R5");
    end
    // R5: re-arm on the expiry edge
    step(1, 8'h80, "R3");
    repeat (3) step(0, 8'h00, "R5");
    step(1, 8'h80, "R5");
    step(1, 8'h0a, "R5");
    repeat (2) step(0, 8'h00, "R5");
    // R3: inexact unlock patterns
    step(1, 8'h81, "R3"); step(1, 8'h03, "R3");
    step(1, 8'h90, "R3"); step(1, 8'h03, "R3");
    step(1, 8'hc0, "R3"); step(1, 8'h03, "R3");
    step(1, 8'h00, "R3"); step(1, 8'h03, "R3");
    // R7: bit7 set with payload while enabled
    step(1, 8'h80, "R3");
    step(1, 8'h85, "R7");
    step(1, 8'hff, "R7");
    step(1, 8'h09, "R6");
    step(0, 8'h00, "R8");
    // R2: reserved bits set in field write
    step(1, 8'h80, "R3");
    step(1, 8'h75, "R2");
    step(0, 8'h00, "R2");
    // R7: write with no unlock
    step(1, 8'h07, "R7");
    step(1, 8'h7f, "R7");
    step(0, 8'h00, "R7");
    repeat (3) @(negedge clk);
    do_reset(1);
    step(1, 8'h80, "R3");
    step(1, 8'h01, "R6");
    repeat (3) step(0, 8'h00, "R8");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R6: %0d items left, expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule